// File: doc/BRIEF.md
# Orbit-Aligned Capture and Playback Memory

This block sits on the per-crossing data path of a single input link. Each crossing carries one entry: an 8-bit tower energy in the upper bits and a small group of feature/fine-grain bits below it. The block tracks the crossing number within the orbit from the orbit-start marker. Depending on the playback mode chosen at the last marker, it either forwards the live entries or substitutes entries from a local memory of one window (256 crossings by default).

Two playback modes exist. In one-shot mode the stored window replaces crossings 0 through DEPTH-1 of every orbit, and the rest of the orbit carries live data. In looping mode the stored window repeats without a break, restarting from entry 0 at every marker. A capture request arms a recorder. Beginning at the next marker it stores DEPTH consecutive live crossings and then raises a done flag. A host port reads the memory at any time, and writes it while the block is neither playing back nor capturing.

The live path and the playback path have the same two-cycle latency. Switching modes therefore never moves data in time.

Top module: `orbit_capture_player`

## Requirements
- R1: With playback off (mode code 00, or the unused code 11), `out_data_o` equals `live_data_i` from two clock cycles earlier.
- R2: A cycle with `bc0_i` high carries crossing 0. Each later cycle carries the next crossing number, which wraps to 0 after ORBIT_LEN-1.
- R3: In one-shot mode (code 01), crossing n of the orbit comes out as stored entry n for n < DEPTH, and as the live entry for all later crossings. The latency is the same as in R1.
- R4: In looping mode (code 10), crossing n comes out as stored entry n mod DEPTH, where n counts from the last orbit marker.
- R5: `mode_i` is sampled only in a cycle where `bc0_i` is high. A change in any other cycle has no effect until the next marker.
- R6: A pulse on `cap_req_i` clears `cap_done_o` and arms the recorder. Starting at the next marker, crossings 0..DEPTH-1 are written to entries 0..DEPTH-1, and after that `cap_done_o` is set.
- R7: Each entry is `{energy[7:0], flags}`, with the energy in the upper bits. With the block idle, a host write stores `host_wdata_i` at `host_addr_i`. `host_rdata_o` returns the entry at `host_addr_i` one cycle after that address is presented.
- R8: A host write while a playback mode is active or a capture is running leaves the memory unchanged and sets `wr_err_o`. Only reset clears `wr_err_o`.
- R9: After reset, `out_data_o`, `cap_done_o` and `wr_err_o` are 0 and playback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bc0_i | input | 1 | Orbit-start marker; this cycle is crossing 0 |
| live_data_i | input | ENERGY_W+FLAG_W | Incoming entry for this crossing |
| mode_i | input | 2 | Playback mode: 00 off, 01 one-shot, 10 looping, 11 off |
| cap_req_i | input | 1 | Pulse that arms a capture at the next marker |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | log2(DEPTH) | Host entry address |
| host_wdata_i | input | ENERGY_W+FLAG_W | Host write entry |
| out_data_o | output | ENERGY_W+FLAG_W | Entry sent downstream |
| host_rdata_o | output | ENERGY_W+FLAG_W | Entry at the host address, one cycle later |
| cap_done_o | output | 1 | A full window has been recorded |
| wr_err_o | output | 1 | Sticky flag: a host write was refused |

## Verification
The assertions assume that orbit markers are spaced exactly ORBIT_LEN cycles apart, so the crossing counter never has to wrap on its own between two markers. They also assume that a capture request never arrives in the same cycle as a marker, and never while a capture is still running. The bench raises the marker on a strict ORBIT_LEN period and places every capture request in the middle of an orbit. It runs a small configuration of 16 entries and 40-crossing orbits, so that every crossing of several orbits can be compared with an expected value computed from the crossing index and a bench-side copy of the memory contents.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    PB_OFF  = 2'b00,
    PB_ONCE = 2'b01,
    PB_LOOP = 2'b10
  } pb_mode_e;

  // Unused code 11 falls back to the live path.
  function automatic pb_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   decode_mode = PB_ONCE;
      2'b10:   decode_mode = PB_LOOP;
      default: decode_mode = PB_OFF;
    endcase
  endfunction

endpackage

// File: rtl/ocp_bx_track.sv
module ocp_bx_track #(
  parameter int ORBIT_LEN = 3564,
  parameter int DEPTH     = 256,
  localparam int BXW      = $clog2(ORBIT_LEN),
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bc0_i,
  output logic [BXW-1:0] bx_q,
  output logic [AW-1:0]  slot_q,
  output logic [AW-1:0]  slot_nxt_o
);

  localparam logic [BXW-1:0] BX_LAST = BXW'(ORBIT_LEN - 1);

  logic [BXW-1:0] bx_d;
  logic [AW-1:0]  slot_d;

  always_comb begin
    if (bc0_i) begin
      bx_d   = '0;
      slot_d = '0;
    end else begin
      bx_d   = (bx_q == BX_LAST) ? '0 : bx_q + 1'b1;
      slot_d = slot_q + 1'b1;
    end
  end

  assign slot_nxt_o = slot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q   <= '0;
      slot_q <= '0;
    end else begin
      bx_q   <= bx_d;
      slot_q <= slot_d;
    end
  end

  assert_bc0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bc0_i |=> (bx_q == '0) && (slot_q == '0));

  assert_bx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc0_i && bx_q != BX_LAST) |=> (bx_q == $past(bx_q) + 1'b1));

endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bc0_i,
  input  logic [1:0]    mode_i,
  input  logic          cap_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] slot_q,
  output pb_mode_e      mode_q,
  output logic          cap_we_o,
  output logic          host_we_ok_o,
  output logic          cap_done_o,
  output logic          wr_err_o
);

  localparam logic [AW-1:0] SLOT_LAST = AW'(DEPTH - 1);

  pb_mode_e mode_d;
  logic     armed_q, armed_d;
  logic     run_q, run_d;
  logic     done_d, err_d;
  logic     busy;
  logic     run_end;

  assign run_end = run_q && (slot_q == SLOT_LAST);
  assign busy    = (mode_q != PB_OFF) || run_q;

  always_comb begin
    mode_d  = bc0_i ? decode_mode(mode_i) : mode_q;
    armed_d = cap_req_i || (armed_q && !bc0_i);
    if (bc0_i && armed_q)  run_d = 1'b1;
    else if (run_end)      run_d = 1'b0;
    else                   run_d = run_q;
    if (cap_req_i)         done_d = 1'b0;
    else if (run_end)      done_d = 1'b1;
    else                   done_d = cap_done_o;
    err_d = wr_err_o || (host_we_i && busy);
  end

  assign cap_we_o     = run_q;
  assign host_we_ok_o = host_we_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PB_OFF;
      armed_q    <= 1'b0;
      run_q      <= 1'b0;
      cap_done_o <= 1'b0;
      wr_err_o   <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      armed_q    <= armed_d;
      run_q      <= run_d;
      cap_done_o <= done_d;
      wr_err_o   <= err_d;
    end
  end

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bc0_i |=> $stable(mode_q));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |=> wr_err_o);

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we_i && (mode_q != PB_OFF)) |=> wr_err_o);

  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_done_o) |-> $past(run_q));

endmodule

// File: rtl/ocp_store.sv
module ocp_store #(
  parameter int W     = 12,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_q,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_a_q <= '0;
      rdata_b_q <= '0;
    end else begin
      rdata_a_q <= mem[raddr_a_i];
      rdata_b_q <= mem[raddr_b_i];
    end
  end

endmodule

// File: rtl/orbit_capture_player.sv
module orbit_capture_player
  import ocp_pkg::*;
#(
  parameter int ENERGY_W  = 8,
  parameter int FLAG_W    = 4,
  parameter int DEPTH     = 256,
  parameter int ORBIT_LEN = 3564
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bc0_i,
  input  logic [ENERGY_W+FLAG_W-1:0]   live_data_i,
  input  logic [1:0]                   mode_i,
  input  logic                         cap_req_i,
  input  logic                         host_we_i,
  input  logic [$clog2(DEPTH)-1:0]     host_addr_i,
  input  logic [ENERGY_W+FLAG_W-1:0]   host_wdata_i,
  output logic [ENERGY_W+FLAG_W-1:0]   out_data_o,
  output logic [ENERGY_W+FLAG_W-1:0]   host_rdata_o,
  output logic                         cap_done_o,
  output logic                         wr_err_o
);

  localparam int W   = ENERGY_W + FLAG_W;
  localparam int AW  = $clog2(DEPTH);
  localparam int BXW = $clog2(ORBIT_LEN);

  logic [BXW-1:0] bx_q;
  logic [AW-1:0]  slot_q, slot_nxt;
  pb_mode_e       mode_q;
  logic           cap_we, host_we_ok;
  logic [W-1:0]   data_q, play_q, out_d;
  logic           use_store;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr;
  logic [W-1:0]   mem_wdata;

  ocp_bx_track #(.ORBIT_LEN(ORBIT_LEN), .DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .bc0_i(bc0_i),
    .bx_q(bx_q), .slot_q(slot_q), .slot_nxt_o(slot_nxt)
  );

  ocp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bc0_i(bc0_i), .mode_i(mode_i),
    .cap_req_i(cap_req_i), .host_we_i(host_we_i), .slot_q(slot_q),
    .mode_q(mode_q), .cap_we_o(cap_we), .host_we_ok_o(host_we_ok),
    .cap_done_o(cap_done_o), .wr_err_o(wr_err_o)
  );

  // Capture owns the write port while it runs; the host is refused then.
  assign mem_we    = cap_we || host_we_ok;
  assign mem_waddr = cap_we ? slot_q : host_addr_i;
  assign mem_wdata = cap_we ? data_q : host_wdata_i;

  ocp_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_a_i(slot_nxt), .rdata_a_q(play_q),
    .raddr_b_i(host_addr_i), .rdata_b_q(host_rdata_o)
  );

  always_comb begin
    use_store = (mode_q == PB_LOOP) ||
                ((mode_q == PB_ONCE) && (int'(bx_q) < DEPTH));
    out_d     = use_store ? play_q : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      out_data_o <= '0;
    end else begin
      data_q     <= live_data_i;
      out_data_o <= out_d;
    end
  end

endmodule

// File: tb/tb_orbit_capture_player.sv
module tb_orbit_capture_player;

  localparam int EW  = 8;
  localparam int FW  = 4;
  localparam int W   = EW + FW;
  localparam int DEP = 16;
  localparam int ORB = 40;
  localparam int AW  = $clog2(DEP);

  logic clk = 1'b0;
  logic rst_n;
  logic bc0;
  logic [W-1:0] live;
  logic [1:0] mode_in;
  logic cap_req, host_we;
  logic [AW-1:0] host_addr;
  logic [W-1:0] host_wdata;
  logic [W-1:0] out_data, host_rdata;
  logic cap_done, wr_err;

  always #2 clk = ~clk;

  orbit_capture_player #(.ENERGY_W(EW), .FLAG_W(FW), .DEPTH(DEP), .ORBIT_LEN(ORB)) dut (
    .clk(clk), .rst_n(rst_n), .bc0_i(bc0), .live_data_i(live), .mode_i(mode_in),
    .cap_req_i(cap_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .out_data_o(out_data), .host_rdata_o(host_rdata),
    .cap_done_o(cap_done), .wr_err_o(wr_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [W-1:0] mem_m [DEP];
  int  step = 0;
  int  bx = 0;
  int  mmode = 0;
  bit  armed_m = 1'b0;
  bit  cap_on = 1'b0;
  logic [W-1:0] pexp [2];
  int  ptag [2];
  int  pn = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (step %0d)", req, act, exp, step);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      1: tag_name = "R1 live path";
      3: tag_name = "R3 one-shot";
      4: tag_name = "R4 looping";
      default: tag_name = "R3 live tail";
    endcase
  endfunction

  task automatic tick();
    logic [W-1:0] e;
    int t;
    @(negedge clk);
    if (pn >= 2) chk(out_data == pexp[1], tag_name(ptag[1]), 32'(out_data), 32'(pexp[1]));
    pexp[1] = pexp[0];
    ptag[1] = ptag[0];
    bc0 = (step % ORB == 0);
    if (bc0) begin
      bx = 0;
      mmode = (mode_in == 2'b01) ? 1 : (mode_in == 2'b10) ? 2 : 0;  // R5: sampled at marker only
      if (armed_m) begin cap_on = 1'b1; armed_m = 1'b0; end
    end else begin
      bx = (bx + 1) % ORB;  // R2
    end
    if (cap_req) armed_m = 1'b1;
    live = W'(step * 29 + 7);
    if (mmode == 2)                    begin e = mem_m[bx % DEP]; t = 4; end
    else if (mmode == 1 && bx < DEP)   begin e = mem_m[bx];       t = 3; end
    else if (mmode == 1)               begin e = live;            t = 5; end
    else                               begin e = live;            t = 1; end
    pexp[0] = e;
    ptag[0] = t;
    if (cap_on) begin
      mem_m[bx] = live;
      if (bx == DEP - 1) cap_on = 1'b0;
    end
    step++;
    pn++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_bx(input int b);
    tick();
    while (bx != b) tick();
  endtask

  task automatic host_write(input int a, input logic [W-1:0] d, input bit accept);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    tick();
    host_we = 1'b0;
    if (accept) mem_m[a] = d;
  endtask

  task automatic host_check(input int a, input string req);
    host_addr = AW'(a);
    tick();
    tick();
    chk(host_rdata == mem_m[a], req, 32'(host_rdata), 32'(mem_m[a]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bc0 = 1'b0; live = '0; mode_in = 2'b00; cap_req = 1'b0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(out_data == '0, "R9 out", 32'(out_data), 0);
    chk(cap_done == 1'b0, "R9 done", 32'(cap_done), 0);
    chk(wr_err == 1'b0, "R9 err", 32'(wr_err), 0);

    run(2 * ORB);  // R1 live latency

    // R7: fill memory while idle, then read back
    for (int a = 0; a < DEP; a++) host_write(a, W'(a * 53 + 11) ^ {EW'(a), FW'(0)}, 1'b1);
    for (int a = 0; a < DEP; a++) host_check(a, "R7 host readback");
    chk(wr_err == 1'b0, "R7 no error when idle", 32'(wr_err), 0);

    // R5: mode change mid-orbit waits for the marker; R3 one-shot
    wait_bx(20);
    mode_in = 2'b01;
    wait_bx(5);
    wait_bx(5);
    // R8: write refused during playback
    host_write(3, 12'hABC, 1'b0);
    tick();
    chk(wr_err == 1'b1, "R8 error set", 32'(wr_err), 1);
    host_check(3, "R8 memory unchanged");
    wait_bx(ORB - 1);
    run(ORB);

    // R4 looping mode
    wait_bx(30);
    mode_in = 2'b10;
    run(2 * ORB);

    // R1 with unused code 11, then R6 capture
    wait_bx(10);
    mode_in = 2'b11;
    wait_bx(5);
    cap_req = 1'b1;
    tick();
    cap_req = 1'b0;
    chk(cap_done == 1'b0, "R6 done clear while armed", 32'(cap_done), 0);
    wait_bx(30);
    wait_bx(30);
    chk(cap_done == 1'b1, "R6 done after window", 32'(cap_done), 1);
    for (int a = 0; a < DEP; a++) host_check(a, "R6 captured entry");
    chk(wr_err == 1'b1, "R8 error sticky", 32'(wr_err), 1);

    // R6: new request clears done; second capture then one-shot replay
    wait_bx(8);
    cap_req = 1'b1;
    tick();
    cap_req = 1'b0;
    chk(cap_done == 1'b0, "R6 done cleared by request", 32'(cap_done), 0);
    wait_bx(20);
    wait_bx(20);
    chk(cap_done == 1'b1, "R6 second capture done", 32'(cap_done), 1);
    mode_in = 2'b01;
    wait_bx(ORB - 1);
    run(ORB + 2);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule